// File: doc/BRIEF.md
# Four-Lane Signed Sum-of-Products Filter Accumulator

The block is the arithmetic core of a small image filter. Four lanes each hold a signed 10-bit sample and a signed 11-bit weight in input registers. Every clock, the four products are summed. The sum either starts a fresh accumulation or is added to the running total in a 25-bit accumulator. A 16-bit slice of that accumulator goes to an output register with a clock enable. The slice is the top bits in fractional format or the bottom bits in integer format.

Each lane has its own partial-load flag, and one shared steering bit applies to all lanes. Together they decide whether a lane loads its sample, its weight, or both. Filter taps can therefore be reloaded while samples stream, or the reverse.

A new sum in fractional mode gets a half-LSB rounding term. Running accumulation adds no further rounding, so roundoff does not build up. An output-off input blanks the bus and drops the valid flag.

Data and weights enter the input registers on one clock edge. The accumulate and format controls must be presented in the next cycle, which is when those registered values feed the accumulator. The result appears on the edge after that.

Top module: `quad_mac_filter`

## Requirements
- R1: A synchronous active-high `rst` clears every input register, the accumulator and the output register, so with `out_off` low the `result` bus reads 0 on the cycle after reset.
- R2: When `lane_part[i]` is 0, both the sample and the weight register of lane i load from `data_in` and `coef_in` (lane i occupies bits [10*i+9:10*i] and [11*i+10:11*i]).
- R3: When `lane_part[i]` is 1 and `part_coef` is 0, lane i loads only its sample and its weight register keeps its value.
- R4: When `lane_part[i]` is 1 and `part_coef` is 1, lane i loads only its weight and its sample register keeps its value.
- R5: With `acc_en` 0 on a clock edge, the accumulator drops its previous content and takes the signed sum of the four lane products held in the input registers.
- R6: With `acc_en` 1 on a clock edge, the sum of the four lane products is added to the accumulator, wrapping modulo 2^25 with no saturation.
- R7: `fmt_int` 0 selects accumulator bits [24:9] as the result and `fmt_int` 1 selects bits [15:0]. The format is sampled on the same edge as `acc_en`.
- R8: The constant 2^8 is added to a new sum only when both `acc_en` and `fmt_int` are 0 on that edge. Accumulating edges and integer-format edges add no rounding.
- R9: With `out_hold` 1 the output register keeps its value while the accumulator keeps updating. With `out_hold` 0 it loads the selected slice.
- R10: With `out_off` 1, `result` is all zeros and `result_valid` is 0. With `out_off` 0, `result` shows the output register and `result_valid` is 1.
- R11: Inputs registered on edge k, with controls presented for edge k+1, yield their result after edge k+2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst | input | 1 | Synchronous active-high reset |
| data_in | input | 40 | Four signed 10-bit samples, lane 0 in the low bits |
| coef_in | input | 44 | Four signed 11-bit weights, lane 0 in the low bits |
| lane_part | input | 4 | Per-lane partial-load flag, 0 loads both registers |
| part_coef | input | 1 | Shared steering for partial loads: 0 sample, 1 weight |
| acc_en | input | 1 | 1 adds to the running total, 0 starts a new sum |
| fmt_int | input | 1 | 0 fractional upper slice, 1 integer lower slice |
| out_hold | input | 1 | 1 freezes the output register |
| out_off | input | 1 | 1 blanks the result bus |
| result | output | 16 | Registered 16-bit result or zero when blanked |
| result_valid | output | 1 | High when the result bus is driven |

## Verification
The bound checker watches the load steering of every lane on every cycle: full loads copy the input and each partial mode freezes the other register. It also confirms that reset clears the state, that a held output register stays put, and that blanking zeros the bus. The arithmetic itself can only be shown by the bench's scenarios. This covers signed products at the range limits, the half-LSB rounding and when it is absent, running accumulation, and the two slice formats. It also covers the one-cycle lag between operands and controls, and the accumulation that continues underneath a held output.

// File: rtl/filter_pkg.sv
package filter_pkg;

   typedef enum logic [1:0] {
      LOAD_BOTH = 2'd0,
      LOAD_DATA = 2'd1,
      LOAD_COEF = 2'd2
   } lane_load_e;

   function automatic lane_load_e lane_mode(input logic part, input logic steer);
      if (!part)
         return LOAD_BOTH;
      else if (steer)
         return LOAD_COEF;
      else
         return LOAD_DATA;
   endfunction

   function automatic int unsigned sum_growth(input int unsigned lanes);
      return (lanes <= 1) ? 0 : $clog2(lanes);
   endfunction

endpackage

// File: rtl/lane_regs.sv
module lane_regs #(
   parameter int DW = 10,
   parameter int CW = 11
) (
   input  logic          clk,
   input  logic          rst,
   input  logic [DW-1:0] d_in,
   input  logic [CW-1:0] c_in,
   input  logic          part,
   input  logic          steer,
   output logic [DW-1:0] d_q,
   output logic [CW-1:0] c_q
);
   import filter_pkg::*;

   lane_load_e mode;
   logic       load_d;
   logic       load_c;

   always_comb begin
      mode   = lane_mode(part, steer);
      load_d = (mode == LOAD_BOTH) || (mode == LOAD_DATA);
      load_c = (mode == LOAD_BOTH) || (mode == LOAD_COEF);
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         d_q <= '0;
         c_q <= '0;
      end else begin
         if (load_d) d_q <= d_in;
         if (load_c) c_q <= c_in;
      end
   end

endmodule

// File: rtl/sop_accum.sv
module sop_accum #(
   parameter int LANES    = 4,
   parameter int DW       = 10,
   parameter int CW       = 11,
   parameter int OW       = 16,
   parameter int ACC_W    = 25,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                  clk,
   input  logic                  rst,
   input  logic [LANES*DW-1:0]   d_flat,
   input  logic [LANES*CW-1:0]   c_flat,
   input  logic                  acc_en,
   input  logic                  fmt_int,
   output logic [ACC_W-1:0]      acc_q,
   output logic                  fmt_q
);
   localparam int PROD_W = DW + CW;
   localparam int SUM_W  = PROD_W + filter_pkg::sum_growth(LANES);
   localparam int RND_SH = ACC_W - OW - 1;

   logic [PROD_W-1:0] prod [LANES];
   logic [ACC_W-1:0]  sop;
   logic [ACC_W-1:0]  rnd;

   for (genvar g = 0; g < LANES; g++) begin : g_mul
      logic [PROD_W-1:0] dx;
      logic [PROD_W-1:0] cx;
      assign dx = {{(PROD_W-DW){d_flat[g*DW+DW-1]}}, d_flat[g*DW +: DW]};
      assign cx = {{(PROD_W-CW){c_flat[g*CW+CW-1]}}, c_flat[g*CW +: CW]};
      assign prod[g] = $signed(dx) * $signed(cx);
   end

   always_comb begin
      sop = '0;
      for (int i = 0; i < LANES; i++)
         sop = sop + {{(ACC_W-PROD_W){prod[i][PROD_W-1]}}, prod[i]};
   end

   if (ROUND_EN) begin : g_round
      always_comb begin
         if (!acc_en && !fmt_int)
            rnd = ACC_W'(1) << RND_SH;
         else
            rnd = '0;
      end
   end else begin : g_noround
      assign rnd = '0;
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         acc_q <= '0;
         fmt_q <= 1'b0;
      end else begin
         fmt_q <= fmt_int;
         if (acc_en)
            acc_q <= acc_q + sop;
         else
            acc_q <= sop + rnd;
      end
   end

   if (SUM_W > ACC_W) begin : g_chk_sum
      $error("sop_accum: accumulator narrower than one sum of products");
   end
   if (ROUND_EN && (RND_SH < 0)) begin : g_chk_rnd
      $error("sop_accum: rounding needs an accumulator wider than the output");
   end

endmodule

// File: rtl/out_stage.sv
module out_stage #(
   parameter int OW    = 16,
   parameter int ACC_W = 25
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [ACC_W-1:0] acc_q,
   input  logic             fmt_q,
   input  logic             out_hold,
   input  logic             out_off,
   output logic [OW-1:0]    hold_q,
   output logic [OW-1:0]    result,
   output logic             result_valid
);
   logic [OW-1:0] slice_frac;
   logic [OW-1:0] slice_int;
   logic [OW-1:0] slice_sel;

   assign slice_frac = acc_q[ACC_W-1 -: OW];
   assign slice_int  = acc_q[OW-1:0];
   assign slice_sel  = fmt_q ? slice_int : slice_frac;

   always_ff @(posedge clk) begin
      if (rst)
         hold_q <= '0;
      else if (!out_hold)
         hold_q <= slice_sel;
   end

   assign result       = out_off ? '0 : hold_q;
   assign result_valid = !out_off;

endmodule

// File: rtl/quad_mac_filter.sv
module quad_mac_filter #(
   parameter int LANES    = 4,
   parameter int DW       = 10,
   parameter int CW       = 11,
   parameter int OW       = 16,
   parameter int ACC_W    = 25,
   parameter bit ROUND_EN = 1'b1
) (
   input  logic                clk,
   input  logic                rst,
   input  logic [LANES*DW-1:0] data_in,
   input  logic [LANES*CW-1:0] coef_in,
   input  logic [LANES-1:0]    lane_part,
   input  logic                part_coef,
   input  logic                acc_en,
   input  logic                fmt_int,
   input  logic                out_hold,
   input  logic                out_off,
   output logic [OW-1:0]       result,
   output logic                result_valid
);
   logic [LANES*DW-1:0] data_q_flat;
   logic [LANES*CW-1:0] coef_q_flat;
   logic [ACC_W-1:0]    acc_q;
   logic                fmt_q;
   logic [OW-1:0]       hold_q;

   if (LANES < 1) begin : g_chk_lanes
      $error("quad_mac_filter: LANES must be at least 1");
   end
   if (OW > ACC_W) begin : g_chk_ow
      $error("quad_mac_filter: output wider than accumulator");
   end
   if ((DW < 2) || (CW < 2)) begin : g_chk_w
      $error("quad_mac_filter: operand widths must be at least 2");
   end

   for (genvar g = 0; g < LANES; g++) begin : g_lane
      lane_regs #(.DW(DW), .CW(CW)) u_lane (
         .clk   (clk),
         .rst   (rst),
         .d_in  (data_in[g*DW +: DW]),
         .c_in  (coef_in[g*CW +: CW]),
         .part  (lane_part[g]),
         .steer (part_coef),
         .d_q   (data_q_flat[g*DW +: DW]),
         .c_q   (coef_q_flat[g*CW +: CW])
      );
   end

   sop_accum #(
      .LANES(LANES), .DW(DW), .CW(CW), .OW(OW), .ACC_W(ACC_W), .ROUND_EN(ROUND_EN)
   ) u_acc (
      .clk     (clk),
      .rst     (rst),
      .d_flat  (data_q_flat),
      .c_flat  (coef_q_flat),
      .acc_en  (acc_en),
      .fmt_int (fmt_int),
      .acc_q   (acc_q),
      .fmt_q   (fmt_q)
   );

   out_stage #(.OW(OW), .ACC_W(ACC_W)) u_out (
      .clk          (clk),
      .rst          (rst),
      .acc_q        (acc_q),
      .fmt_q        (fmt_q),
      .out_hold     (out_hold),
      .out_off      (out_off),
      .hold_q       (hold_q),
      .result       (result),
      .result_valid (result_valid)
   );

endmodule

// File: rtl/quad_mac_filter_chk.sv
module quad_mac_filter_chk #(
   parameter int LANES = 4,
   parameter int DW    = 10,
   parameter int CW    = 11,
   parameter int OW    = 16,
   parameter int ACC_W = 25
) (
   input logic                clk,
   input logic                rst,
   input logic [LANES*DW-1:0] data_in,
   input logic [LANES*CW-1:0] coef_in,
   input logic [LANES-1:0]    lane_part,
   input logic                part_coef,
   input logic                out_hold,
   input logic                out_off,
   input logic [OW-1:0]       result,
   input logic                result_valid,
   input logic [LANES*DW-1:0] data_q_flat,
   input logic [LANES*CW-1:0] coef_q_flat,
   input logic [ACC_W-1:0]    acc_q,
   input logic [OW-1:0]       hold_q
);

   assert_reset_clears_R1: assert property (@(posedge clk)
      $past(rst) |-> (acc_q == '0 && hold_q == '0 && data_q_flat == '0 && coef_q_flat == '0));

   assert_hold_keeps_R9: assert property (@(posedge clk) disable iff (rst)
      out_hold |=> $stable(hold_q));

   assert_blank_bus_R10: assert property (@(posedge clk) disable iff (rst)
      out_off |-> (result == '0 && !result_valid));

   assert_drive_bus_R10: assert property (@(posedge clk) disable iff (rst)
      !out_off |-> (result == hold_q && result_valid));

   for (genvar g = 0; g < LANES; g++) begin : g_lane_chk
      assert_load_both_R2: assert property (@(posedge clk) disable iff (rst)
         !lane_part[g] |=> (data_q_flat[g*DW +: DW] == $past(data_in[g*DW +: DW]) &&
                            coef_q_flat[g*CW +: CW] == $past(coef_in[g*CW +: CW])));

      assert_coef_frozen_R3: assert property (@(posedge clk) disable iff (rst)
         (lane_part[g] && !part_coef) |=> ($stable(coef_q_flat[g*CW +: CW]) &&
                            data_q_flat[g*DW +: DW] == $past(data_in[g*DW +: DW])));

      assert_data_frozen_R4: assert property (@(posedge clk) disable iff (rst)
         (lane_part[g] && part_coef) |=> ($stable(data_q_flat[g*DW +: DW]) &&
                            coef_q_flat[g*CW +: CW] == $past(coef_in[g*CW +: CW])));
   end

endmodule

bind quad_mac_filter quad_mac_filter_chk #(
   .LANES(LANES), .DW(DW), .CW(CW), .OW(OW), .ACC_W(ACC_W)
) u_chk (
   .clk          (clk),
   .rst          (rst),
   .data_in      (data_in),
   .coef_in      (coef_in),
   .lane_part    (lane_part),
   .part_coef    (part_coef),
   .out_hold     (out_hold),
   .out_off      (out_off),
   .result       (result),
   .result_valid (result_valid),
   .data_q_flat  (data_q_flat),
   .coef_q_flat  (coef_q_flat),
   .acc_q        (acc_q),
   .hold_q       (hold_q)
);

// File: tb/tb_quad_mac_filter.sv
module tb_quad_mac_filter;
   localparam int CLK_PERIOD = 10;

   logic        clk = 1'b0;
   logic        rst = 1'b1;
   logic [39:0] data_in = '0;
   logic [43:0] coef_in = '0;
   logic [3:0]  lane_part = '0;
   logic        part_coef = 1'b0;
   logic        acc_en = 1'b0;
   logic        fmt_int = 1'b0;
   logic        out_hold = 1'b0;
   logic        out_off = 1'b0;
   logic [15:0] result;
   logic        result_valid;

   int checks = 0;
   int failures = 0;
   bit done = 1'b0;

   logic [15:0] q_res [$];
   logic        q_val [$];
   string       q_tag [$];

   // reference state, built from the requirements
   logic signed [9:0]  md [4];
   logic signed [10:0] mc [4];
   logic signed [24:0] macc;
   logic               mfmt;
   logic [15:0]        mout;

   quad_mac_filter dut (
      .clk(clk), .rst(rst), .data_in(data_in), .coef_in(coef_in),
      .lane_part(lane_part), .part_coef(part_coef), .acc_en(acc_en),
      .fmt_int(fmt_int), .out_hold(out_hold), .out_off(out_off),
      .result(result), .result_valid(result_valid)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   function automatic logic [39:0] d4(input int a, input int b, input int c, input int e);
      return {10'(e), 10'(c), 10'(b), 10'(a)};
   endfunction

   function automatic logic [43:0] c4(input int a, input int b, input int c, input int e);
      return {11'(e), 11'(c), 11'(b), 11'(a)};
   endfunction

   task automatic drive(input logic [39:0] d, input logic [43:0] c, input logic [3:0] part,
                        input logic pc, input logic ae, input logic fi, input logic oh,
                        input logic oo, input logic r, input string tag);
      logic signed [24:0] s;
      logic [15:0] nout;
      @(negedge clk);
      data_in = d; coef_in = c; lane_part = part; part_coef = pc;
      acc_en = ae; fmt_int = fi; out_hold = oh; out_off = oo; rst = r;
      @(posedge clk);
      // R11: output register takes the accumulator formed one edge earlier
      if (r) nout = '0;
      else if (oh) nout = mout;                          // R9
      else nout = mfmt ? macc[15:0] : macc[24:9];        // R7
      s = '0;
      for (int i = 0; i < 4; i++) s = s + 25'(md[i]) * 25'(mc[i]);
      if (r) macc = '0;
      else if (ae) macc = macc + s;                      // R6
      else macc = s + ((!fi) ? 25'sd256 : 25'sd0);       // R5, R8
      mfmt = r ? 1'b0 : fi;
      for (int i = 0; i < 4; i++) begin
         if (r) begin md[i] = '0; mc[i] = '0; end
         else begin
            if (!part[i] || !pc) md[i] = d[i*10 +: 10];  // R2, R3
            if (!part[i] || pc)  mc[i] = c[i*11 +: 11];  // R2, R4
         end
      end
      mout = nout;
      q_res.push_back(oo ? 16'h0 : nout);                // R10
      q_val.push_back(!oo);
      q_tag.push_back(tag);
   endtask

   task automatic idle(input logic ae, input logic fi, input string tag);
      drive('0, '0, 4'h0, 1'b0, ae, fi, 1'b0, 1'b0, 1'b0, tag);
   endtask

   // scoreboard monitor
   always @(posedge clk) begin
      #1;
      if (q_res.size() > 0) begin
         logic [15:0] er;
         logic ev;
         string t;
         er = q_res.pop_front();
         ev = q_val.pop_front();
         t  = q_tag.pop_front();
         checks++;
         if (result !== er || result_valid !== ev) begin
            failures++;
            $display("FAIL %s: result=%h valid=%b expected result=%h valid=%b",
                     t, result, result_valid, er, ev);
         end
      end
   end

   initial begin
      #(CLK_PERIOD * 100000);
      if (!done) begin
         failures++;
         $display("FAIL watchdog: run did not complete, actual=hung expected=done");
         $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
         $finish;
      end
   end

   initial begin
      logic [31:0] lf;
      macc = '0; mfmt = 1'b0; mout = '0;
      for (int i = 0; i < 4; i++) begin md[i] = '0; mc[i] = '0; end

      // R1 reset state
      for (int k = 0; k < 3; k++)
         drive(d4(5,6,7,8), c4(1,2,3,4), 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b1, "R1 reset");
      idle(1'b0, 1'b0, "R1 after reset");

      // R8 rounding on a new fractional sum: 1*256 plus 256 gives 512, slice = 1
      drive(d4(1,0,0,0), c4(256,0,0,0), 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R2 load");
      idle(1'b0, 1'b0, "R5 R8 new sum");
      idle(1'b0, 1'b0, "R8 round result");
      // R8: same operands accumulated, no extra rounding
      drive(d4(1,0,0,0), c4(256,0,0,0), 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 load");
      drive(d4(1,0,0,0), c4(256,0,0,0), 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R8 round");
      drive('0, '0, 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 R8 accum no round");
      idle(1'b0, 1'b1, "R8 result");
      idle(1'b0, 1'b1, "R8 result");

      // R7 integer format, mixed signs
      drive(d4(3,-2,5,7), c4(4,100,-3,1), 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R7 load");
      idle(1'b0, 1'b1, "R7 integer sum");
      idle(1'b0, 1'b1, "R7 integer result");

      // R6 running accumulation in integer format
      drive(d4(10,20,30,40), c4(1,1,1,1), 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 load");
      drive(d4(-5,0,0,0), c4(7,0,0,0), 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R6 first");
      drive(d4(100,0,0,0), c4(-3,0,0,0), 4'h0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R6 add");
      idle(1'b1, 1'b1, "R6 add");
      idle(1'b0, 1'b1, "R6 result");
      idle(1'b0, 1'b1, "R6 result");

      // R3 / R4 partial loads
      drive(d4(1,1,1,1), c4(50,50,50,50), 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 both");
      drive(d4(2,2,2,2), c4(999,999,999,999), 4'hF, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R3 data only");
      drive(d4(77,77,77,77), c4(3,3,3,3), 4'hF, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R4 coef only");
      drive(d4(9,9,9,9), c4(9,9,9,9), 4'b0101, 1'b1, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R2 R4 mixed lanes");
      idle(1'b0, 1'b1, "R3 R4 result");
      idle(1'b0, 1'b1, "R3 R4 result");
      idle(1'b0, 1'b1, "R3 R4 result");

      // R9 hold while accumulating
      drive(d4(1,2,3,4), c4(5,6,7,8), 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R9 load");
      drive(d4(1,2,3,4), c4(5,6,7,8), 4'hF, 1'b0, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, "R9 hold");
      for (int k = 0; k < 4; k++)
         drive(d4(1,2,3,4), c4(5,6,7,8), 4'hF, 1'b0, 1'b1, 1'b1, 1'b1, 1'b0, 1'b0, "R9 hold accum");
      drive(d4(1,2,3,4), c4(5,6,7,8), 4'hF, 1'b0, 1'b1, 1'b1, 1'b0, 1'b0, 1'b0, "R9 release");
      idle(1'b0, 1'b1, "R9 released value");

      // R10 blanking
      drive(d4(100,0,0,0), c4(100,0,0,0), 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R10 off");
      drive('0, '0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0, "R10 off");
      drive('0, '0, 4'h0, 1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, "R10 on");

      // extremes, fractional, accumulating
      drive(d4(-512,-512,-512,-512), c4(-1024,-1024,-1024,-1024), 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 extreme load");
      drive(d4(-512,511,-512,511), c4(-1024,1023,1023,-1024), 4'h0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 1'b0, "R5 extreme");
      for (int k = 0; k < 6; k++)
         drive(d4(-512,-512,-512,-512), c4(-1024,-1024,-1024,-1024), 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b0, "R6 extreme wrap");
      idle(1'b1, 1'b0, "R6 extreme");
      idle(1'b0, 1'b0, "R7 extreme frac");

      // mid-run reset
      drive(d4(33,0,0,0), c4(33,0,0,0), 4'h0, 1'b0, 1'b1, 1'b0, 1'b0, 1'b0, 1'b1, "R1 mid reset");
      idle(1'b1, 1'b1, "R1 after mid reset");
      idle(1'b1, 1'b1, "R1 after mid reset");

      // pseudo-random traffic
      lf = 32'hACE1_2357;
      for (int k = 0; k < 600; k++) begin
         logic [39:0] rd;
         logic [43:0] rc;
         logic [31:0] ctl;
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         rd = {lf, lf[31:24]} ^ {8'h0, lf[15:0], lf[31:16]};
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         rc = {lf[11:0], lf} ^ {12'h0, lf[7:0], lf[31:8]};
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         ctl = lf;
         drive(rd, rc, ctl[3:0], ctl[4], ctl[5], ctl[6], (ctl[9:7] == 3'b0),
               (ctl[12:10] == 3'b0), 1'b0, "R11 random");
      end
      idle(1'b0, 1'b0, "R11 flush");
      idle(1'b0, 1'b0, "R11 flush");

      @(posedge clk);
      #2;
      if (q_res.size() != 0) begin
         failures++;
         $display("FAIL R11 scoreboard: pending=%0d expected=0", q_res.size());
      end
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
   end

endmodule